// File: doc/BRIEF.md
# Video Line and Field Sequencer

This block derives raster timing from the system clock. A cycle counter measures one scan line and a line counter measures one frame. Two timing standards are supported, one with 263 lines per frame and one with 314. The standard is chosen by an input and is taken up only at frame boundaries. The number of system cycles per line comes from a fixed-point constant shifted right by 12 bits. With the default multipliers, 8791293 and 8836089, this gives 2146 and 2157 cycles per line.

The block produces a tick at the end of every line, a pulse when vertical blanking begins at line 240, and a pulse at the end of every frame. It also produces a 32-bit frame count and a 32-bit status word. The status word holds the current line number, a blanking flag and two field-indicator bits, which toggle from frame to frame in interlaced operation. Timer channels that are configured to re-synchronise on the vertical sync receive a reset strobe at each frame end.

Top module: `vid_line_field_seq`

## Requirements
- R1: While `rst_n` is low, all strobes are 0, `status` is 0 and `frame_cnt` is 0. Counting starts at cycle 0 of line 0 under the 263-line standard.
- R2: `hblank_tick` is high for one cycle at the end of every line. A line lasts `MUL >> 12` system cycles, where `MUL` is the multiplier of the standard in force (2146 cycles for the 263-line standard, 2157 for the 314-line standard).
- R3: A frame has 263 lines when the latched standard is 0 and 314 lines when it is 1. `frame_end` is high during the last cycle of the last line, and the line number then wraps to 0.
- R4: `std_pal` is sampled only in a `frame_end` cycle. A change at any other time has no effect on line length or frame length until the next frame starts.
- R5: `vblank_start` is high in the last cycle of line 239, so the line number becomes 240 on the next cycle. `status[14]` is 1 exactly when the line number is 240 or more.
- R6: `status[31]` is cleared when blanking starts. At each frame end it is loaded with the field value, or with 0 when the frame is not interlaced.
- R7: `frame_cnt` increments by one at each frame end. The field value is bit 0 of the incremented count.
- R8: At each frame end, `status[13]` becomes 1 when either bit of `ilace_bits` is 0. When `ilace_bits` is 2'b11 it becomes the inverse of the field value.
- R9: For each timer channel i, `tmr_rst[i]` is high exactly in `frame_end` cycles in which `tmr_mode[3i+2:3i]` equals 3'b011 or 3'b101 (bit 0 enables sync, bits 2:1 select sync mode 1 or 2). Otherwise it is 0.
- R10: `status[LW-1:0]` holds the current line number, with LW = clog2(max lines + 1). All status bits not named here read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_pal | input | 1 | Timing standard request: 0 = 263-line, 1 = 314-line |
| ilace_bits | input | 2 | Interlace control; both set selects interlaced field toggling |
| tmr_mode | input | 3*N_SYNC_TMR | Low three mode bits of each timer channel |
| hblank_tick | output | 1 | One-cycle tick at line end |
| vblank_start | output | 1 | One-cycle pulse when blanking begins |
| frame_end | output | 1 | One-cycle pulse in the last cycle of the frame |
| tmr_rst | output | N_SYNC_TMR | Per-channel counter reset strobe |
| status | output | 32 | Line number, blanking flag and field bits |
| frame_cnt | output | 32 | Completed frame count |

## Verification
The assertions assume that the blanking line is below both frame lengths and that every line is at least two cycles long. The bench keeps to these limits by shrinking the configuration to 5- and 7-cycle lines, 9- and 11-line frames and blanking at line 6. It also gives the 5-cycle multiplier a nonzero fraction, so the shift is exercised. Inputs change only on falling edges. `std_pal`, `ilace_bits` and the mode fields are swept on independent periods, so each value is present at both frame ends and mid-frame, and a reset is applied in the middle of the run.

// File: rtl/vlf_pkg.sv
package vlf_pkg;
  localparam int unsigned ST_FIELD_BIT = 31;
  localparam int unsigned ST_BLANK_BIT = 14;
  localparam int unsigned ST_ALT_BIT   = 13;

  typedef enum logic [1:0] {
    SYNC_OFF  = 2'b00,
    SYNC_RST1 = 2'b01,
    SYNC_RST2 = 2'b10,
    SYNC_STOP = 2'b11
  } sync_sel_e;

  function automatic logic frame_resync(input logic [2:0] mode);
    sync_sel_e sel;
    sel = sync_sel_e'(mode[2:1]);
    return mode[0] && (sel == SYNC_RST1 || sel == SYNC_RST2);
  endfunction
endpackage

// File: rtl/vlf_cycle_ctr.sv
module vlf_cycle_ctr #(
  parameter int unsigned LEN_A = 2146,
  parameter int unsigned LEN_B = 2157,
  localparam int unsigned LEN_MAX = (LEN_A > LEN_B) ? LEN_A : LEN_B,
  localparam int unsigned CW = $clog2(LEN_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_b,
  output logic line_end
);
  localparam logic [CW-1:0] LAST_A = CW'(LEN_A - 1);
  localparam logic [CW-1:0] LAST_B = CW'(LEN_B - 1);

  logic [CW-1:0] cyc_q, cyc_d;
  logic [CW-1:0] last;

  always_comb begin
    last     = sel_b ? LAST_B : LAST_A;
    line_end = (cyc_q == last);
    cyc_d    = line_end ? '0 : cyc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_d;
  end

  // R2
  cyc_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q <= last);
  // R2
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (cyc_q == '0));
endmodule

// File: rtl/vlf_line_ctr.sv
module vlf_line_ctr #(
  parameter int unsigned LINES_A = 263,
  parameter int unsigned LINES_B = 314,
  parameter int unsigned VBL_LINE = 240,
  localparam int unsigned LMAX = (LINES_A > LINES_B) ? LINES_A : LINES_B,
  localparam int unsigned LW = $clog2(LMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_b,
  input  logic          line_end,
  output logic [LW-1:0] line_q,
  output logic          vbl_start,
  output logic          frm_end,
  output logic          in_blank
);
  localparam logic [LW-1:0] LAST_A  = LW'(LINES_A - 1);
  localparam logic [LW-1:0] LAST_B  = LW'(LINES_B - 1);
  localparam logic [LW-1:0] VBL     = LW'(VBL_LINE);
  localparam logic [LW-1:0] PRE_VBL = LW'(VBL_LINE - 1);

  logic [LW-1:0] line_d;
  logic [LW-1:0] last;
  logic          line_en;

  always_comb begin
    last      = sel_b ? LAST_B : LAST_A;
    line_en   = line_end;
    frm_end   = line_end && (line_q == last);
    vbl_start = line_end && (line_q == PRE_VBL);
    in_blank  = (line_q >= VBL);
    line_d    = frm_end ? '0 : line_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= '0;
    else if (line_en) line_q <= line_d;
  end

  // R3
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_end |=> (line_q == '0));
  // R5
  vbl_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vbl_start |=> (line_q == VBL));
  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(line_q));
endmodule

// File: rtl/vlf_status.sv
module vlf_status #(
  parameter int unsigned LW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_end,
  input  logic          vbl_start,
  input  logic          in_blank,
  input  logic [1:0]    ilace_bits,
  input  logic [LW-1:0] line,
  output logic [31:0]   status,
  output logic [31:0]   frame_cnt
);
  import vlf_pkg::*;

  logic [31:0] fc_q, fc_d;
  logic        fld_q, fld_d;
  logic        alt_q, alt_d;
  logic        ilace;
  logic        field;

  always_comb begin
    ilace = &ilace_bits;
    fc_d  = fc_q + 32'd1;
    field = fc_d[0];
    fld_d = fld_q;
    alt_d = alt_q;
    if (vbl_start) fld_d = 1'b0;
    if (frm_end) begin
      fld_d = ilace & field;
      alt_d = ~(ilace & field);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fc_q  <= '0;
      fld_q <= 1'b0;
      alt_q <= 1'b0;
    end else begin
      if (frm_end) fc_q <= fc_d;
      if (frm_end || vbl_start) fld_q <= fld_d;
      if (frm_end) alt_q <= alt_d;
    end
  end

  always_comb begin
    status               = '0;
    status[LW-1:0]       = line;
    status[ST_BLANK_BIT] = in_blank;
    status[ST_ALT_BIT]   = alt_q;
    status[ST_FIELD_BIT] = fld_q;
    frame_cnt            = fc_q;
  end

  // R7
  frame_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_end |=> (frame_cnt == $past(frame_cnt) + 32'd1));
  // R6
  field_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vbl_start && !frm_end) |=> !status[ST_FIELD_BIT]);
  // R8
  alt_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_end && (&ilace_bits)) |=> (status[ST_ALT_BIT] != status[ST_FIELD_BIT]));
  // R8
  alt_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_end && !(&ilace_bits)) |=> (status[ST_ALT_BIT] && !status[ST_FIELD_BIT]));
endmodule

// File: rtl/vid_line_field_seq.sv
module vid_line_field_seq #(
  parameter int unsigned MUL_NTSC   = 8791293,
  parameter int unsigned MUL_PAL    = 8836089,
  parameter int unsigned FRAC_SH    = 12,
  parameter int unsigned LINES_NTSC = 263,
  parameter int unsigned LINES_PAL  = 314,
  parameter int unsigned VBL_LINE   = 240,
  parameter int unsigned N_SYNC_TMR = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    std_pal,
  input  logic [1:0]              ilace_bits,
  input  logic [3*N_SYNC_TMR-1:0] tmr_mode,
  output logic                    hblank_tick,
  output logic                    vblank_start,
  output logic                    frame_end,
  output logic [N_SYNC_TMR-1:0]   tmr_rst,
  output logic [31:0]             status,
  output logic [31:0]             frame_cnt
);
  import vlf_pkg::*;

  localparam int unsigned CYC_NTSC = MUL_NTSC >> FRAC_SH;
  localparam int unsigned CYC_PAL  = MUL_PAL >> FRAC_SH;
  localparam int unsigned LMAX = (LINES_NTSC > LINES_PAL) ? LINES_NTSC : LINES_PAL;
  localparam int unsigned LW   = $clog2(LMAX + 1);

  logic          std_q, std_d;
  logic          line_end;
  logic          vbl_start;
  logic          frm_end;
  logic          in_blank;
  logic [LW-1:0] line_q;

  always_comb std_d = std_pal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       std_q <= 1'b0;
    else if (frm_end) std_q <= std_d;
  end

  vlf_cycle_ctr #(.LEN_A(CYC_NTSC), .LEN_B(CYC_PAL)) cyc_u (
    .clk(clk), .rst_n(rst_n), .sel_b(std_q), .line_end(line_end)
  );

  vlf_line_ctr #(.LINES_A(LINES_NTSC), .LINES_B(LINES_PAL), .VBL_LINE(VBL_LINE)) line_u (
    .clk(clk), .rst_n(rst_n), .sel_b(std_q), .line_end(line_end),
    .line_q(line_q), .vbl_start(vbl_start), .frm_end(frm_end), .in_blank(in_blank)
  );

  vlf_status #(.LW(LW)) stat_u (
    .clk(clk), .rst_n(rst_n), .frm_end(frm_end), .vbl_start(vbl_start),
    .in_blank(in_blank), .ilace_bits(ilace_bits), .line(line_q),
    .status(status), .frame_cnt(frame_cnt)
  );

  for (genvar i = 0; i < N_SYNC_TMR; i++) begin : g_tmr
    assign tmr_rst[i] = frm_end && frame_resync(tmr_mode[3*i +: 3]);

    // R9
    tmr_rst_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_rst[i] |-> frame_end);
  end

  assign hblank_tick  = line_end;
  assign vblank_start = vbl_start;
  assign frame_end    = frm_end;

  // R4
  std_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(std_q));
  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_tick |=> !hblank_tick);
  // R5
  vbl_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_start |-> hblank_tick);
endmodule

// File: tb/vid_line_field_seq_tb_top.sv
module vid_line_field_seq_tb_top;
  localparam int unsigned LA = 9, LB = 11, VB = 6, CA = 5, CB = 7, NT = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        std_pal;
  logic [1:0]  ilace_bits;
  logic [5:0]  tmr_mode;
  logic        hblank_tick, vblank_start, frame_end;
  logic [1:0]  tmr_rst;
  logic [31:0] status, frame_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vid_line_field_seq #(
    .MUL_NTSC((CA << 12) + 1234), .MUL_PAL(CB << 12), .FRAC_SH(12),
    .LINES_NTSC(LA), .LINES_PAL(LB), .VBL_LINE(VB), .N_SYNC_TMR(NT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .std_pal(std_pal), .ilace_bits(ilace_bits),
    .tmr_mode(tmr_mode), .hblank_tick(hblank_tick), .vblank_start(vblank_start),
    .frame_end(frame_end), .tmr_rst(tmr_rst), .status(status), .frame_cnt(frame_cnt)
  );

  task automatic chk(input string req, input string what, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
    end
  endtask

  // reference state
  int m_cyc, m_line, m_fc;
  bit m_std, m_fld, m_alt;

  task automatic m_reset();
    m_cyc = 0; m_line = 0; m_fc = 0; m_std = 0; m_fld = 0; m_alt = 0;
  endtask

  initial begin
    rst_n = 1'b0; std_pal = 1'b1; ilace_bits = 2'b00; tmr_mode = '0;
    m_reset();
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      rst_n      = !(k < 3 || (k >= 3000 && k < 3004));
      std_pal    = ((k / 37) % 2) == 1;
      ilace_bits = 2'((k / 101) % 4);
      for (int i = 0; i < NT; i++) tmr_mode[3*i +: 3] = 3'((k / 7 + 3 * i) % 8);
      #1;
      if (!rst_n) begin
        m_reset();
        chk("R1", "hblank_tick", hblank_tick, 0);
        chk("R1", "vblank_start", vblank_start, 0);
        chk("R1", "frame_end", frame_end, 0);
        chk("R1", "tmr_rst", tmr_rst, 0);
        chk("R1", "status", status, 0);
        chk("R1", "frame_cnt", frame_cnt, 0);
      end else begin
        int  lc, lt;
        bit  e_ht, e_vs, e_fe;
        lc   = m_std ? CB : CA;
        lt   = m_std ? LB : LA;
        e_ht = (m_cyc == lc - 1);
        e_vs = e_ht && (m_line == VB - 1);
        e_fe = e_ht && (m_line == lt - 1);
        chk("R2", "hblank_tick", hblank_tick, e_ht);
        chk("R5", "vblank_start", vblank_start, e_vs);
        chk("R3", "frame_end", frame_end, e_fe);
        chk("R10", "status line", status[7:0], m_line);
        chk("R10", "status spare bits", status & ~32'h8000_60FF, 0);
        chk("R5", "status blank", status[14], m_line >= VB);
        chk("R6", "status field", status[31], m_fld);
        chk("R8", "status alt", status[13], m_alt);
        chk("R7", "frame_cnt", frame_cnt, m_fc);
        for (int i = 0; i < NT; i++) begin
          logic [2:0] md;
          md = tmr_mode[3*i +: 3];
          chk("R9", "tmr_rst", tmr_rst[i], e_fe && (md == 3'b011 || md == 3'b101));
        end
        // advance reference to the next rising edge (R4: std taken only at frame end)
        if (e_vs) m_fld = 0;
        if (e_fe) begin
          bit il, f;
          m_fc++;
          il    = (ilace_bits == 2'b11);
          f     = m_fc[0];
          m_fld = il & f;
          m_alt = !(il & f);
          m_std = std_pal;
        end
        if (e_ht) begin
          m_cyc  = 0;
          m_line = e_fe ? 0 : m_line + 1;
        end else m_cyc++;
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule